// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is a synthesizable behavioural model of a parallel NOR flash device. The device is driven by a classic two-write unlock command set. Bus writes pass through a sequencer that tracks which write of a command sequence is in progress. The sequencer recognises these operations:

- byte program
- identifier (autoselect) reads
- an unlock-bypass shortcut for repeated programming
- chip erase and sector erase
- suspending and resuming a sector erase

Bus reads return one of three things, depending on the active operation:

- the stored array bytes
- the manufacturer and device identifier words
- a status word whose bits toggle from one read to the next

The array is a small register memory split into equal sectors, and it comes out of reset erased (all bytes 0xFF). Program and erase take a fixed number of clock cycles: 2^PG_LOG for program, 2^SE_LOG for sector erase and 2^CE_LOG for chip erase. A host polls the status word until the toggling stops, which tells it the operation has finished.

Command bytes are compared on data bits 7:0. The two unlock addresses are parameters. A sector is selected by the top SECT_W address bits. Read data is registered: a read requested on one clock edge appears on `rdata` after that edge.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is in read-array mode, `rdata` is 0x00 and every array byte reads 0xFF.
- R2: A sequence begins only with data 0xAA at address UNLK_A. The second write must be 0x55 at UNLK_B. Any other first write, or a wrong second write, leaves the block in read-array mode, and the writes that follow are not taken as a command.
- R3: Writing 0xA0 at UNLK_A after the two unlock writes arms a program. The next write (address, data) sets the stored byte to old AND new. The new value is readable once the 2^PG_LOG program cycles have passed.
- R4: Writing 0x90 at UNLK_A after the two unlock writes enters identifier mode. In this mode a read with addr[1:0]=0 returns MFR_ID, addr[1:0]=1 returns DEV_ID, and any other offset returns 0x00. Any write returns the block to read-array mode.
- R5: While a program or erase runs, every read returns a status word. Bit 6 of this word inverts from one read to the next, and all bits other than 6 and 2 are 0.
- R6: Status bit 2 inverts on each read during chip or sector erase. It holds its value on each read during a program.
- R7: Writing 0x80 after the first unlock pair, then a second unlock pair, then 0x10 at UNLK_A sets every byte to 0xFF after 2^CE_LOG cycles. A 0x10 written at any other address aborts the sequence and leaves the array unchanged.
- R8: Writing 0x30 as the final erase byte, at any address, sets every byte of that address's sector to 0xFF after 2^SE_LOG cycles. Other sectors are left unchanged.
- R9: Reads issued between the writes of the erase sequence return array data.
- R10: A 0xB0 write during sector erase suspends it, and reads then return array data. A later 0x30 write resumes the erase and restarts the full 2^SE_LOG count.
- R11: While an erase is suspended, a program sequence aimed at another sector takes effect. A program aimed at the sector being erased is ignored.
- R12: All writes are ignored while chip erase runs, including 0xB0 and unlock writes.
- R13: Writing 0x20 at UNLK_A after the two unlock writes enters bypass mode. In bypass, a single 0xA0 write (any address) arms a program. Writing 0x90 and then 0x00 leaves bypass, after which a lone 0xA0 write does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe for one cycle |
| rd_en | input | 1 | Bus read strobe for one cycle |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | DATA_W | Write data; command bytes use bits 7:0 |
| rdata | output | DATA_W | Registered read data |

## Verification
A corrupted sequencer state shows up on the very next read. Examples are a lost unlock step, a stuck bypass flag, or a suspend that was not recorded. In each case the block returns status where array data was due, or array data where identifier or status words were due. It can also make the write that follows either take effect or be dropped when it should not. A timer that does not restart on resume shows up as the erase finishing too early. The bench catches this by sampling status a fixed number of cycles after the resume write. Errors in the array update show up as wrong byte values on the first read after the operation ends.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_UNL1, S_CMD, S_AUTO, S_PGDATA,
      S_ERU0, S_ERU1, S_ERCMD, S_BYPX,
      S_PROG, S_CERASE, S_SERASE
   } seq_st_t;

   typedef enum logic [1:0] {OPL_PROG, OPL_SECT, OPL_CHIP} op_len_t;

   localparam logic [7:0] K_UNLK_1   = 8'hAA;
   localparam logic [7:0] K_UNLK_2   = 8'h55;
   localparam logic [7:0] K_PROG     = 8'hA0;
   localparam logic [7:0] K_IDENT    = 8'h90;
   localparam logic [7:0] K_ERASE    = 8'h80;
   localparam logic [7:0] K_BYPASS   = 8'h20;
   localparam logic [7:0] K_CHIP     = 8'h10;
   localparam logic [7:0] K_SECT     = 8'h30;
   localparam logic [7:0] K_SUSP     = 8'hB0;
   localparam logic [7:0] K_BYP_EXIT = 8'h00;

   function automatic logic is_busy(seq_st_t s);
      return (s == S_PROG) || (s == S_CERASE) || (s == S_SERASE);
   endfunction

   function automatic logic is_erase(seq_st_t s);
      return (s == S_CERASE) || (s == S_SERASE);
   endfunction

endpackage

// File: rtl/nfs_op_timer.sv
module nfs_op_timer
   import nfs_pkg::*;
#(
   parameter int unsigned PG_LOG = 2,
   parameter int unsigned SE_LOG = 4,
   parameter int unsigned CE_LOG = 5
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  op_len_t len_sel,
   input  logic    run,
   output logic    done
);
   localparam int unsigned MAX_A = (PG_LOG > SE_LOG) ? PG_LOG : SE_LOG;
   localparam int unsigned MAX_LOG = (MAX_A > CE_LOG) ? MAX_A : CE_LOG;
   localparam int unsigned CNT_W = MAX_LOG + 1;
   localparam logic [CNT_W-1:0] LEN_PG = CNT_W'((64'd1 << PG_LOG) - 64'd1);
   localparam logic [CNT_W-1:0] LEN_SE = CNT_W'((64'd1 << SE_LOG) - 64'd1);
   localparam logic [CNT_W-1:0] LEN_CE = CNT_W'((64'd1 << CE_LOG) - 64'd1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] len_val;

   always_comb begin
      case (len_sel)
         OPL_PROG: len_val = LEN_PG;
         OPL_CHIP: len_val = LEN_CE;
         default:  len_val = LEN_SE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= len_val;
      else if (run && cnt != '0)    cnt <= cnt - CNT_W'(1);
   end

   assign done = run && !load && (cnt == '0);
endmodule

// File: rtl/nfs_array.sv
module nfs_array #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned SECT_W = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [DATA_W-1:0] prog_data,
   input  logic              sect_clr,
   input  logic [SECT_W-1:0] clr_sect,
   input  logic              chip_clr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned OFS_W      = ADDR_W - SECT_W;
   localparam int unsigned N_SECT     = 1 << SECT_W;
   localparam int unsigned SECT_BYTES = 1 << OFS_W;

   logic [DATA_W-1:0] sect_rd [N_SECT];

   for (genvar s = 0; s < N_SECT; s++) begin : g_sect
      logic [DATA_W-1:0] bank [SECT_BYTES];
      logic              wipe;
      logic              hit;

      assign wipe = chip_clr || (sect_clr && clr_sect == SECT_W'(s));
      assign hit  = prog_en && prog_addr[ADDR_W-1:OFS_W] == SECT_W'(s);

      always_ff @(posedge clk) begin
         for (int j = 0; j < SECT_BYTES; j++) begin
            if (!rst_n || wipe)
               bank[j] <= '1;
            else if (hit && prog_addr[OFS_W-1:0] == OFS_W'(j))
               bank[j] <= bank[j] & prog_data;
         end
      end

      assign sect_rd[s] = bank[rd_addr[OFS_W-1:0]];
   end

   assign rd_data = sect_rd[rd_addr[ADDR_W-1:OFS_W]];
endmodule

// File: rtl/nfs_seq_fsm.sv
module nfs_seq_fsm
   import nfs_pkg::*;
#(
   parameter int unsigned       ADDR_W = 6,
   parameter int unsigned       SECT_W = 2,
   parameter int unsigned       DATA_W = 8,
   parameter logic [ADDR_W-1:0] UNLK_A = 'h15,
   parameter logic [ADDR_W-1:0] UNLK_B = 'h2A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              op_done,
   output seq_st_t           st,
   output logic              byp,
   output logic              susp,
   output logic [SECT_W-1:0] esect,
   output logic [ADDR_W-1:0] pg_addr,
   output logic [DATA_W-1:0] pg_data,
   output logic              tmr_load,
   output op_len_t           tmr_len
);
   seq_st_t           nst;
   logic              nbyp, nsusp;
   logic [SECT_W-1:0] nesect;
   logic [ADDR_W-1:0] npga;
   logic [DATA_W-1:0] npgd;
   logic [7:0]        cb;
   logic              at_a, at_b;

   assign cb   = wdata[7:0];
   assign at_a = (addr == UNLK_A);
   assign at_b = (addr == UNLK_B);

   always_comb begin
      nst = st; nbyp = byp; nsusp = susp; nesect = esect;
      npga = pg_addr; npgd = pg_data;
      if (op_done) begin
         nst = S_IDLE;
      end else if (wr_en) begin
         case (st)
            S_IDLE: begin
               if (susp && cb == K_SECT) begin
                  nst = S_SERASE; nsusp = 1'b0;
               end else if (byp) begin
                  if (cb == K_PROG)       nst = S_PGDATA;
                  else if (cb == K_IDENT) nst = S_BYPX;
               end else if (at_a && cb == K_UNLK_1) begin
                  nst = S_UNL1;
               end
            end
            S_UNL1: nst = (at_b && cb == K_UNLK_2) ? S_CMD : S_IDLE;
            S_CMD: begin
               nst = S_IDLE;
               if (at_a) begin
                  if (cb == K_PROG)                  nst = S_PGDATA;
                  else if (!susp && cb == K_IDENT)   nst = S_AUTO;
                  else if (!susp && cb == K_ERASE)   nst = S_ERU0;
                  else if (!susp && cb == K_BYPASS)  nbyp = 1'b1;
               end
            end
            S_AUTO: nst = S_IDLE;
            S_PGDATA: begin
               npga = addr; npgd = wdata;
               nst = (susp && addr[ADDR_W-1:ADDR_W-SECT_W] == esect) ? S_IDLE : S_PROG;
            end
            S_ERU0: nst = (at_a && cb == K_UNLK_1) ? S_ERU1 : S_IDLE;
            S_ERU1: nst = (at_b && cb == K_UNLK_2) ? S_ERCMD : S_IDLE;
            S_ERCMD: begin
               nst = S_IDLE;
               if (cb == K_CHIP && at_a) begin
                  nst = S_CERASE;
               end else if (cb == K_SECT) begin
                  nst = S_SERASE; nesect = addr[ADDR_W-1:ADDR_W-SECT_W];
               end
            end
            S_BYPX: begin
               if (cb == K_BYP_EXIT) nbyp = 1'b0;
               nst = S_IDLE;
            end
            S_SERASE: if (cb == K_SUSP) begin
               nst = S_IDLE; nsusp = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= S_IDLE; byp <= 1'b0; susp <= 1'b0;
         esect <= '0; pg_addr <= '0; pg_data <= '0;
      end else begin
         st <= nst; byp <= nbyp; susp <= nsusp;
         esect <= nesect; pg_addr <= npga; pg_data <= npgd;
      end
   end

   assign tmr_load = is_busy(nst) && (nst != st);
   assign tmr_len  = (nst == S_PROG) ? OPL_PROG :
                     (nst == S_CERASE) ? OPL_CHIP : OPL_SECT;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nfs_pkg::*;
#(
   parameter int unsigned       ADDR_W = 6,
   parameter int unsigned       SECT_W = 2,
   parameter int unsigned       DATA_W = 8,
   parameter logic [ADDR_W-1:0] UNLK_A = 'h15,
   parameter logic [ADDR_W-1:0] UNLK_B = 'h2A,
   parameter logic [DATA_W-1:0] MFR_ID = 'hC2,
   parameter logic [DATA_W-1:0] DEV_ID = 'h4D,
   parameter int unsigned       PG_LOG = 2,
   parameter int unsigned       SE_LOG = 4,
   parameter int unsigned       CE_LOG = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   initial begin
      assert (SECT_W >= 1 && SECT_W < ADDR_W) else $error("SECT_W out of range");
      assert (UNLK_A != UNLK_B) else $error("unlock addresses must differ");
      assert (DATA_W >= 8) else $error("DATA_W must hold a command byte");
      assert (ADDR_W <= 12) else $error("array too large for a register memory");
   end

   seq_st_t           seq_st;
   logic              byp_on, susp_on, op_done, tmr_load;
   op_len_t           tmr_len;
   logic [SECT_W-1:0] esect;
   logic [ADDR_W-1:0] pg_addr;
   logic [DATA_W-1:0] pg_data, arr_rd, rd_word;
   logic              t6, t2;

   nfs_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W),
                 .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)) fsm_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .op_done(op_done), .st(seq_st), .byp(byp_on), .susp(susp_on),
      .esect(esect), .pg_addr(pg_addr), .pg_data(pg_data),
      .tmr_load(tmr_load), .tmr_len(tmr_len));

   nfs_op_timer #(.PG_LOG(PG_LOG), .SE_LOG(SE_LOG), .CE_LOG(CE_LOG)) tmr_i (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .len_sel(tmr_len),
      .run(is_busy(seq_st)), .done(op_done));

   nfs_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W)) arr_i (
      .clk(clk), .rst_n(rst_n),
      .prog_en(op_done && seq_st == S_PROG),
      .prog_addr(pg_addr), .prog_data(pg_data),
      .sect_clr(op_done && seq_st == S_SERASE), .clr_sect(esect),
      .chip_clr(op_done && seq_st == S_CERASE),
      .rd_addr(addr), .rd_data(arr_rd));

   always_comb begin
      rd_word = arr_rd;
      if (is_busy(seq_st)) begin
         rd_word    = '0;
         rd_word[6] = t6;
         rd_word[2] = t2;
      end else if (seq_st == S_AUTO) begin
         case (addr[1:0])
            2'd0:    rd_word = MFR_ID;
            2'd1:    rd_word = DEV_ID;
            default: rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0; t6 <= 1'b0; t2 <= 1'b0;
      end else if (rd_en) begin
         rdata <= rd_word;
         if (is_busy(seq_st))  t6 <= ~t6;
         if (is_erase(seq_st)) t2 <= ~t2;
      end
   end
endmodule

// File: rtl/nfs_chk.sv
module nfs_chk
   import nfs_pkg::*;
#(
   parameter int unsigned       ADDR_W = 6,
   parameter int unsigned       DATA_W = 8,
   parameter logic [ADDR_W-1:0] UNLK_A = 'h15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input seq_st_t           st,
   input logic              byp,
   input logic              susp
);
   assert_bad_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && !byp && !susp && wr_en && !(addr == UNLK_A && wdata[7:0] == 8'hAA))
      |=> st == S_IDLE);

   assert_dq6_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && is_busy(st) && $past(rd_en && is_busy(st)))
      |=> rdata[6] != $past(rdata[6]));

   assert_dq2_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && st == S_PROG && $past(rd_en && st == S_PROG))
      |=> rdata[2] == $past(rdata[2]));

   assert_susp_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp) |-> $past(st == S_SERASE && wr_en && wdata[7:0] == 8'hB0));

   assert_ce_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CERASE && wr_en) |=> ((st == S_CERASE || st == S_IDLE) && $stable(byp) && !susp));

   assert_byp_exit_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (byp && st == S_BYPX && wr_en && wdata[7:0] == 8'h00) |=> !byp);
endmodule

bind nor_cmd_seq nfs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLK_A(UNLK_A)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .st(seq_st), .byp(byp_on), .susp(susp_on));

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
   localparam logic [5:0] U0 = 6'h15;
   localparam logic [5:0] U1 = 6'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [5:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   int         checks = 0;
   int         errors = 0;

   always #2 clk = ~clk;

   nor_cmd_seq dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                      .addr(addr), .wdata(wdata), .rdata(rdata));

   typedef struct packed {
      logic [1:0] op;   // 0 write, 1 read-check, 2 idle d cycles, 3 unlock pair + command d
      logic [5:0] a;
      logic [7:0] d;
      logic [7:0] e;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 62;
   localparam vec_t VT [NV] = '{
      '{2'd1,6'h00,8'h00,8'hFF,4'd1},  '{2'd1,6'h3F,8'h00,8'hFF,4'd1},   // R1 erased array
      '{2'd3,6'h00,8'hA0,8'h00,4'd0},  '{2'd0,6'h03,8'hA5,8'h00,4'd0},   // R3 program
      '{2'd2,6'h00,8'd8,8'h00,4'd0},   '{2'd1,6'h03,8'h00,8'hA5,4'd3},
      '{2'd3,6'h00,8'hA0,8'h00,4'd0},  '{2'd0,6'h03,8'h3C,8'h00,4'd0},   // R3 AND
      '{2'd2,6'h00,8'd8,8'h00,4'd0},   '{2'd1,6'h03,8'h00,8'h24,4'd3},
      '{2'd0,6'h15,8'hAA,8'h00,4'd0},  '{2'd0,6'h2A,8'h54,8'h00,4'd0},   // R2 bad second cycle
      '{2'd0,6'h15,8'hA0,8'h00,4'd0},  '{2'd0,6'h03,8'h00,8'h00,4'd0},
      '{2'd2,6'h00,8'd8,8'h00,4'd0},   '{2'd1,6'h03,8'h00,8'h24,4'd2},
      '{2'd0,6'h03,8'h00,8'h00,4'd0},  '{2'd1,6'h03,8'h00,8'h24,4'd2},   // R2 stray first write
      '{2'd3,6'h00,8'h90,8'h00,4'd0},  '{2'd1,6'h20,8'h00,8'hC2,4'd4},   // R4 identifier
      '{2'd1,6'h21,8'h00,8'h4D,4'd4},  '{2'd1,6'h23,8'h00,8'h00,4'd4},
      '{2'd0,6'h00,8'hF0,8'h00,4'd0},  '{2'd1,6'h03,8'h00,8'h24,4'd4},
      '{2'd3,6'h00,8'hA0,8'h00,4'd0},  '{2'd0,6'h14,8'h5A,8'h00,4'd0},
      '{2'd2,6'h00,8'd8,8'h00,4'd0},   '{2'd3,6'h00,8'hA0,8'h00,4'd0},
      '{2'd0,6'h25,8'h11,8'h00,4'd0},  '{2'd2,6'h00,8'd8,8'h00,4'd0},
      '{2'd3,6'h00,8'h80,8'h00,4'd0},  '{2'd1,6'h03,8'h00,8'h24,4'd9},   // R9 reads mid-sequence
      '{2'd0,6'h15,8'hAA,8'h00,4'd0},  '{2'd1,6'h14,8'h00,8'h5A,4'd9},
      '{2'd0,6'h2A,8'h55,8'h00,4'd0},  '{2'd0,6'h1F,8'h30,8'h00,4'd0},   // R8 sector 1
      '{2'd2,6'h00,8'd20,8'h00,4'd0},  '{2'd1,6'h14,8'h00,8'hFF,4'd8},
      '{2'd1,6'h03,8'h00,8'h24,4'd8},  '{2'd1,6'h25,8'h00,8'h11,4'd8},
      '{2'd3,6'h00,8'h80,8'h00,4'd0},  '{2'd0,6'h15,8'hAA,8'h00,4'd0},   // R7 bad chip address
      '{2'd0,6'h2A,8'h55,8'h00,4'd0},  '{2'd0,6'h16,8'h10,8'h00,4'd0},
      '{2'd2,6'h00,8'd40,8'h00,4'd0},  '{2'd1,6'h03,8'h00,8'h24,4'd7},
      '{2'd1,6'h25,8'h00,8'h11,4'd7},  '{2'd3,6'h00,8'h20,8'h00,4'd0},   // R13 bypass
      '{2'd0,6'h00,8'hA0,8'h00,4'd0},  '{2'd0,6'h30,8'h0F,8'h00,4'd0},
      '{2'd2,6'h00,8'd8,8'h00,4'd0},   '{2'd1,6'h30,8'h00,8'h0F,4'd13},
      '{2'd0,6'h07,8'hA0,8'h00,4'd0},  '{2'd0,6'h31,8'hF0,8'h00,4'd0},
      '{2'd2,6'h00,8'd8,8'h00,4'd0},   '{2'd1,6'h31,8'h00,8'hF0,4'd13},
      '{2'd0,6'h00,8'h90,8'h00,4'd0},  '{2'd0,6'h00,8'h00,8'h00,4'd0},
      '{2'd0,6'h15,8'hA0,8'h00,4'd0},  '{2'd0,6'h32,8'h00,8'h00,4'd0},
      '{2'd2,6'h00,8'd8,8'h00,4'd0},   '{2'd1,6'h32,8'h00,8'hFF,4'd13}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] r);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      r = rdata;
   endtask

   task automatic cmd(input logic [7:0] c);
      wr(U0, 8'hAA); wr(U1, 8'h55); wr(U0, c);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic erase_pref;
      cmd(8'h80); wr(U0, 8'hAA); wr(U1, 8'h55);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual %h expected %h", 8'h00, 8'h01);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r0, r1, r2;
      repeat (3) @(negedge clk);
      chk("R1 rdata in reset", rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         case (VT[i].op)
            2'd0: wr(VT[i].a, VT[i].d);
            2'd1: begin
               rd(VT[i].a, r0);
               chk($sformatf("R%0d vector %0d", VT[i].rq, i), r0, VT[i].e);
            end
            2'd2: idle(int'(VT[i].d));
            default: cmd(VT[i].d);
         endcase
      end

      // R1: reset mid-run restores erased array and zero read data
      rst_n = 1'b0;
      idle(2);
      chk("R1 rdata after reset", rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      rd(6'h30, r0); chk("R1 array erased by reset", r0, 8'hFF);

      // R12: writes during chip erase are ignored; R7 chip erase result
      cmd(8'hA0); wr(6'h05, 8'h77); idle(8);
      erase_pref(); wr(U0, 8'h10);
      rd(6'h00, r0); rd(6'h00, r1);
      chk("R12 busy before suspend try", {7'd0, r0[6] ^ r1[6]}, 8'h01);
      wr(6'h09, 8'hB0);
      rd(6'h00, r0); rd(6'h00, r1);
      chk("R12 suspend ignored, still toggling", {7'd0, r0[6] ^ r1[6]}, 8'h01);
      wr(U0, 8'hAA); wr(U1, 8'h55);
      idle(40);
      wr(U0, 8'hA0); wr(6'h08, 8'h00); idle(8);
      rd(6'h08, r0); chk("R12 unlock during chip erase dropped", r0, 8'hFF);
      rd(6'h05, r0); chk("R7 chip erase clears byte", r0, 8'hFF);

      // R5/R6: status toggling during sector erase
      erase_pref(); wr(6'h30, 8'h30);
      rd(6'h30, r0); rd(6'h30, r1); rd(6'h30, r2);
      chk("R5 other status bits zero", r0 & 8'hBB, 8'h00);
      chk("R5 bit6 toggles erase a", {7'd0, r0[6] ^ r1[6]}, 8'h01);
      chk("R5 bit6 toggles erase b", {7'd0, r1[6] ^ r2[6]}, 8'h01);
      chk("R6 bit2 toggles erase", {7'd0, r0[2] ^ r1[2]}, 8'h01);
      idle(20);
      // R5/R6: status during program
      cmd(8'hA0); wr(6'h01, 8'h00);
      rd(6'h01, r0); rd(6'h01, r1); rd(6'h01, r2);
      chk("R5 bit6 toggles program", {7'd0, r0[6] ^ r1[6]}, 8'h01);
      chk("R6 bit2 held program a", {7'd0, r0[2] ^ r1[2]}, 8'h00);
      chk("R6 bit2 held program b", {7'd0, r1[2] ^ r2[2]}, 8'h00);
      chk("R5 program other bits zero", r1 & 8'hBB, 8'h00);
      idle(4);

      // R10/R11: suspend, program elsewhere, resume with restart
      cmd(8'hA0); wr(6'h05, 8'h77); idle(8);
      erase_pref(); wr(6'h00, 8'h30);
      idle(6);
      wr(6'h00, 8'hB0);
      rd(6'h05, r0); chk("R10 suspended read returns array", r0, 8'h77);
      cmd(8'hA0); wr(6'h35, 8'h3A); idle(8);
      rd(6'h35, r0); chk("R11 program other sector while suspended", r0, 8'h3A);
      cmd(8'hA0); wr(6'h06, 8'h00); idle(8);
      rd(6'h06, r0); chk("R11 program to erasing sector ignored", r0, 8'hFF);
      wr(6'h11, 8'h30);
      idle(10);
      rd(6'h05, r0); rd(6'h05, r1);
      chk("R10 erase restarted after resume", {7'd0, r0[6] ^ r1[6]}, 8'h01);
      idle(12);
      rd(6'h05, r0); chk("R10 erase completes after resume", r0, 8'hFF);
      rd(6'h35, r0); chk("R11 other sector kept", r0, 8'h3A);
      rd(6'h01, r0); chk("R8 erased sector byte", r0, 8'hFF);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule